// File: doc/BRIEF.md
# Dual-clock 7-to-8 lane gearbox

This block re-packs a sample stream that arrives seven samples wide on a write clock into a stream that leaves eight samples wide on a separate read clock. It sits behind a parallel filter that produces seven lanes per cycle. Downstream logic wants eight lanes per cycle. When the two clock rates keep the aggregate sample rates equal, the pair looks from outside like a filter that produces eight lanes directly. Sample order is preserved exactly: the lowest lane of every word holds the oldest sample.

Storage is a 56-slot sample buffer, addressed per sample. Because 56 is a multiple of both 7 and 8, a write block and a read beat never straddle the wrap point. Each side keeps a count of the blocks it has moved. It passes that count to the other domain as a cyclic Gray code through a two-flop synchroniser. The write side uses the result to judge free space, and the read side uses it to judge how many samples are available. Misuse on either side is recorded in a sticky flag. Each side has its own reset.

Top module: `lane_gearbox`

## Requirements
- R1: A write cycle (wr_valid high) with at least 7 free slots stores all seven lanes. Lane k sits at wr_data bits [16k+15:16k], and lane 0 is the oldest sample.
- R2: Every read handshake (rd_valid and rd_ready high at a read-clock edge) delivers the next eight samples. Lane k sits at rd_data bits [16k+15:16k], with lane 0 the oldest. Over any sequence of writes and reads, the samples come out in exactly the order they were accepted.
- R3: rd_valid is high only while at least eight samples are available according to the synchronised write count. Once high, it stays high until a handshake takes the beat.
- R4: The buffer holds 56 samples. Writes are accepted without overflow as long as at least seven slots are free, and the occupancy seen by either side never exceeds 56.
- R5: A write cycle with fewer than seven free slots is discarded, leaving the stored data and the write position unchanged. It sets wr_overflow, which stays high until the write-side reset.
- R6: rd_ready high while rd_valid is low leaves the read position unchanged. It sets rd_underflow, which stays high until the read-side reset.
- R7: Each side's block count crosses to the other domain as a cyclic Gray code that changes at most one bit per step, through at least two flops. A completed beat is therefore not visible as rd_valid until the second read-clock edge after the write edge.
- R8: wr_rst_n clears the write position and wr_overflow. rd_rst_n clears the read position and rd_underflow. After both resets, rd_valid is low and the stream restarts from an empty buffer.
- R9: Fewer than eight buffered samples are held, with rd_valid low, until later writes complete a beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_valid | input | 1 | Seven-sample block present on wr_data |
| wr_data | input | 112 | Seven 16-bit lanes, lane 0 oldest |
| wr_overflow | output | 1 | Sticky: a block was dropped for lack of space |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_ready | input | 1 | Consumer takes the beat on rd_data |
| rd_valid | output | 1 | Eight samples available on rd_data |
| rd_data | output | 128 | Eight 16-bit lanes, lane 0 oldest |
| rd_underflow | output | 1 | Sticky: a read was attempted with no beat available |

## Verification
On every cycle the assertions check the following: each Gray count changes by at most one bit, a refused write or an idle read leaves its position untouched, both flags are set by their triggering condition and then hold, rd_valid is held until taken, and occupancy stays within 56. Only the scoreboard scenarios can show that samples come out in their exact order, with lane 0 oldest, through partial beats, bursts, stalls, a dropped block and a restart after reset. The same applies to the minimum two-edge crossing delay, which the bench observes at the ports.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
   // Widest block counter the Gray helpers support.
   localparam int unsigned GBX_GW = 8;
   typedef logic [GBX_GW-1:0] gword_t;

   function automatic gword_t to_gray(input gword_t b);
      return b ^ (b >> 1);
   endfunction

   function automatic gword_t from_gray(input gword_t g);
      gword_t b;
      b[GBX_GW-1] = g[GBX_GW-1];
      for (int i = GBX_GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   // Centre an even-length count inside a 2^cw reflected Gray code so the
   // wrap from the last code back to the first flips only the top bit.
   function automatic int unsigned code_offset(input int unsigned modn, input int unsigned cw);
      return ((1 << cw) - modn) / 2;
   endfunction
endpackage

// File: rtl/gbx_blk_ptr.sv
module gbx_blk_ptr
   import gbx_pkg::*;
#(
   parameter int unsigned MODN = 16,
   parameter int unsigned CW   = $clog2(MODN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] gray
);
   localparam int unsigned OFF = code_offset(MODN, CW);
   localparam logic [CW-1:0] GRST = CW'(to_gray(gword_t'(OFF)));

   if (MODN % 2 != 0 || MODN < 2) begin : g_bad_mod
      $error("gbx_blk_ptr: MODN must be even and at least 2");
   end
   if (CW > GBX_GW) begin : g_bad_w
      $error("gbx_blk_ptr: counter wider than Gray helper");
   end

   logic [CW-1:0] nxt;
   logic [CW-1:0] nxt_g;

   always_comb begin
      nxt   = (cnt == CW'(MODN - 1)) ? '0 : cnt + 1'b1;
      nxt_g = CW'(to_gray(gword_t'(nxt) + gword_t'(OFF)));
   end

   // The Gray code is registered in the source domain so it never glitches.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         gray <= GRST;
      end else if (inc) begin
         cnt  <= nxt;
         gray <= nxt_g;
      end
   end
endmodule

// File: rtl/gbx_ptr_sync.sv
module gbx_ptr_sync
   import gbx_pkg::*;
#(
   parameter int unsigned MODN   = 16,
   parameter int unsigned CW     = $clog2(MODN),
   parameter int unsigned STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] gray_in,
   output logic [CW-1:0] cnt_out
);
   localparam int unsigned OFF = code_offset(MODN, CW);
   localparam logic [CW-1:0] GRST = CW'(to_gray(gword_t'(OFF)));

   if (STAGES < 2) begin : g_bad_stages
      $error("gbx_ptr_sync: at least two synchroniser stages required");
   end

   logic [CW-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= GRST;
      end else begin
         stg[0] <= gray_in;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign cnt_out = CW'(from_gray(gword_t'(stg[STAGES-1])) - gword_t'(OFF));
endmodule

// File: rtl/gbx_ram.sv
module gbx_ram #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 56,
   parameter int unsigned WL    = 7,
   parameter int unsigned RL    = 8,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic            wr_clk,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [WL*W-1:0] wdata,
   input  logic [AW-1:0]   raddr,
   output logic [RL*W-1:0] rdata
);
   logic [W-1:0] mem [DEPTH];

   // Block bases are multiples of the lane count, so base+k never passes DEPTH-1.
   always_ff @(posedge wr_clk) begin
      if (we) begin
         for (int k = 0; k < WL; k++) mem[waddr + AW'(k)] <= wdata[k*W +: W];
      end
   end

   for (genvar k = 0; k < RL; k++) begin : g_rd_lane
      assign rdata[k*W +: W] = mem[raddr + AW'(k)];
   end
endmodule

// File: rtl/lane_gearbox.sv
module lane_gearbox #(
   parameter int unsigned SAMPLE_W    = 16,
   parameter int unsigned WR_LANES    = 7,
   parameter int unsigned RD_LANES    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                         wr_clk,
   input  logic                         wr_rst_n,
   input  logic                         wr_valid,
   input  logic [WR_LANES*SAMPLE_W-1:0] wr_data,
   output logic                         wr_overflow,
   input  logic                         rd_clk,
   input  logic                         rd_rst_n,
   input  logic                         rd_ready,
   output logic                         rd_valid,
   output logic [RD_LANES*SAMPLE_W-1:0] rd_data,
   output logic                         rd_underflow
);
   localparam int unsigned DEPTH = WR_LANES * RD_LANES;
   localparam int unsigned SPAN  = 2 * DEPTH;
   localparam int unsigned PW    = $clog2(SPAN + 1);
   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned WMOD  = 2 * RD_LANES;  // write blocks per two buffer laps
   localparam int unsigned RMOD  = 2 * WR_LANES;  // read beats per two buffer laps
   localparam int unsigned WCW   = $clog2(WMOD);
   localparam int unsigned RCW   = $clog2(RMOD);

   if (WR_LANES < 1 || RD_LANES < 1 || SAMPLE_W < 1) begin : g_bad_lanes
      $error("lane_gearbox: lane counts and sample width must be positive");
   end
   if (WCW > gbx_pkg::GBX_GW || RCW > gbx_pkg::GBX_GW) begin : g_bad_cnt
      $error("lane_gearbox: block counters exceed Gray helper width");
   end

   function automatic logic [PW-1:0] span_diff(input logic [PW-1:0] a, input logic [PW-1:0] b);
      return (a >= b) ? (a - b) : (PW'(SPAN) - (b - a));
   endfunction

   function automatic logic [AW-1:0] fold(input logic [PW-1:0] p);
      return AW'((p >= PW'(DEPTH)) ? (p - PW'(DEPTH)) : p);
   endfunction

   // ---------------- write domain ----------------
   logic [WCW-1:0] wr_blk, wr_gray;
   logic [RCW-1:0] rd_blk_w;
   logic [PW-1:0]  wr_pos, rd_pos_w, wr_free;
   logic           wr_accept;

   assign wr_pos    = PW'(wr_blk) * PW'(WR_LANES);
   assign rd_pos_w  = PW'(rd_blk_w) * PW'(RD_LANES);
   assign wr_free   = PW'(DEPTH) - span_diff(wr_pos, rd_pos_w);
   assign wr_accept = wr_valid && (wr_free >= PW'(WR_LANES));

   gbx_blk_ptr #(.MODN(WMOD), .CW(WCW)) u_wptr (
      .clk(wr_clk), .rst_n(wr_rst_n), .inc(wr_accept), .cnt(wr_blk), .gray(wr_gray)
   );

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n)                  wr_overflow <= 1'b0;
      else if (wr_valid && !wr_accept) wr_overflow <= 1'b1;
   end

   // ---------------- read domain ----------------
   logic [RCW-1:0] rd_blk, rd_gray;
   logic [WCW-1:0] wr_blk_r;
   logic [PW-1:0]  rd_pos, wr_pos_r, rd_avail;
   logic           rd_fire;

   assign rd_pos   = PW'(rd_blk) * PW'(RD_LANES);
   assign wr_pos_r = PW'(wr_blk_r) * PW'(WR_LANES);
   assign rd_avail = span_diff(wr_pos_r, rd_pos);
   assign rd_valid = (rd_avail >= PW'(RD_LANES));
   assign rd_fire  = rd_valid && rd_ready;

   gbx_blk_ptr #(.MODN(RMOD), .CW(RCW)) u_rptr (
      .clk(rd_clk), .rst_n(rd_rst_n), .inc(rd_fire), .cnt(rd_blk), .gray(rd_gray)
   );

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n)                 rd_underflow <= 1'b0;
      else if (rd_ready && !rd_valid) rd_underflow <= 1'b1;
   end

   // ---------------- crossings and storage ----------------
   gbx_ptr_sync #(.MODN(WMOD), .CW(WCW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wr_gray), .cnt_out(wr_blk_r)
   );

   gbx_ptr_sync #(.MODN(RMOD), .CW(RCW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(rd_gray), .cnt_out(rd_blk_w)
   );

   gbx_ram #(.W(SAMPLE_W), .DEPTH(DEPTH), .WL(WR_LANES), .RL(RD_LANES), .AW(AW)) u_ram (
      .wr_clk(wr_clk),
      .we    (wr_accept),
      .waddr (fold(wr_pos)),
      .wdata (wr_data),
      .raddr (fold(rd_pos)),
      .rdata (rd_data)
   );
endmodule

// File: rtl/lane_gearbox_chk.sv
module lane_gearbox_chk #(
   parameter int unsigned WR_LANES = 7,
   parameter int unsigned RD_LANES = 8
) (
   input logic                                  wr_clk,
   input logic                                  wr_rst_n,
   input logic                                  wr_valid,
   input logic                                  wr_overflow,
   input logic [$clog2(2*RD_LANES)-1:0]         wr_blk,
   input logic [$clog2(2*RD_LANES)-1:0]         wr_gray,
   input logic [$clog2(4*WR_LANES*RD_LANES+1)-1:0] wr_free,
   input logic                                  rd_clk,
   input logic                                  rd_rst_n,
   input logic                                  rd_ready,
   input logic                                  rd_valid,
   input logic                                  rd_underflow,
   input logic [$clog2(2*WR_LANES)-1:0]         rd_blk,
   input logic [$clog2(2*WR_LANES)-1:0]         rd_gray,
   input logic [$clog2(4*WR_LANES*RD_LANES+1)-1:0] rd_avail
);
   localparam int unsigned DEPTH = WR_LANES * RD_LANES;

   // R5: refused write leaves the position alone and raises the flag
   a_r5_drop_holds_ptr: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_valid && wr_free < WR_LANES) |=> $stable(wr_blk));
   a_r5_overflow_sets: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_valid && wr_free < WR_LANES) |=> wr_overflow);
   a_r5_overflow_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_overflow |=> wr_overflow);

   // R6: empty read attempt leaves the position alone and raises the flag
   a_r6_idle_holds_ptr: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      !(rd_valid && rd_ready) |=> $stable(rd_blk));
   a_r6_underflow_sets: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_ready && !rd_valid) |=> rd_underflow);
   a_r6_underflow_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_underflow |=> rd_underflow);

   // R3: an offered beat stays offered until taken
   a_r3_valid_held: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_valid && !rd_ready) |=> rd_valid);

   // R4: neither side ever sees more than DEPTH samples buffered
   a_r4_wr_bound: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_free <= DEPTH);
   a_r4_rd_bound: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_avail <= DEPTH);

   // R7: crossing codes move by at most one bit per source-clock cycle
   a_r7_wr_gray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $countones(wr_gray ^ $past(wr_gray)) <= 1);
   a_r7_rd_gray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind lane_gearbox lane_gearbox_chk #(.WR_LANES(WR_LANES), .RD_LANES(RD_LANES)) u_chk (
   .wr_clk      (wr_clk),
   .wr_rst_n    (wr_rst_n),
   .wr_valid    (wr_valid),
   .wr_overflow (wr_overflow),
   .wr_blk      (wr_blk),
   .wr_gray     (wr_gray),
   .wr_free     (wr_free),
   .rd_clk      (rd_clk),
   .rd_rst_n    (rd_rst_n),
   .rd_ready    (rd_ready),
   .rd_valid    (rd_valid),
   .rd_underflow(rd_underflow),
   .rd_blk      (rd_blk),
   .rd_gray     (rd_gray),
   .rd_avail    (rd_avail)
);

// File: tb/tb_lane_gearbox.sv
`timescale 1ns/1ps
module tb_lane_gearbox;
   localparam int W  = 16;
   localparam int WL = 7;
   localparam int RL = 8;
   localparam int DEPTH = WL * RL;

   logic wr_clk = 1'b0, rd_clk = 1'b0;
   always #4.0 wr_clk = ~wr_clk;   // 125 MHz
   always #3.5 rd_clk = ~rd_clk;

   logic            wr_rst_n, rd_rst_n, wr_valid, rd_ready;
   logic [WL*W-1:0] wr_data;
   logic [RL*W-1:0] rd_data;
   logic            wr_overflow, rd_valid, rd_underflow;

   lane_gearbox dut (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_overflow(wr_overflow),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ready(rd_ready), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_underflow(rd_underflow)
   );

   int checks = 0, errors = 0, seq = 0, rd_cyc = 0;
   bit rd_en = 1'b0, rd_gap = 1'b0;
   logic [W-1:0] exp_q[$];

   function automatic logic [W-1:0] sval(input int s);
      return 16'(s) ^ 16'h5a00;
   endfunction

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Driver: n blocks, gap idle cycles after each; accepted blocks go to the scoreboard.
   task automatic wr_blocks(input int n, input bit accept, input int gap);
      for (int b = 0; b < n; b++) begin
         @(negedge wr_clk);
         wr_valid = 1'b1;
         for (int k = 0; k < WL; k++) begin
            wr_data[k*W +: W] = sval(seq);
            if (accept) exp_q.push_back(sval(seq));
            seq++;
         end
         for (int g = 0; g < gap; g++) begin
            @(negedge wr_clk);
            wr_valid = 1'b0;
         end
      end
      @(negedge wr_clk);
      wr_valid = 1'b0;
   endtask

   task automatic wait_rd(input int n);
      repeat (n) @(negedge rd_clk);
   endtask

   // Read-ready driver, changes 1 ns after each read edge.
   initial begin
      rd_ready = 1'b0;
      forever begin
         @(posedge rd_clk);
         #1;
         rd_cyc++;
         rd_ready = rd_en && !(rd_gap && (rd_cyc % 4 == 0));
      end
   end

   // Monitor: a beat with valid and ready seen at the falling edge is taken at the next rise.
   initial begin
      forever begin
         @(negedge rd_clk);
         if (rd_rst_n && rd_valid && rd_ready) begin
            if (exp_q.size() < RL) begin
               check(1'b0, "R3", "valid with too few samples queued", exp_q.size(), RL);
            end else begin
               automatic bit bad = 1'b0;
               automatic int bl = 0;
               automatic logic [W-1:0] ba = '0, be = '0;
               for (int k = 0; k < RL; k++) begin
                  automatic logic [W-1:0] e = exp_q.pop_front();
                  if (rd_data[k*W +: W] !== e && !bad) begin
                     bad = 1'b1; bl = k; ba = rd_data[k*W +: W]; be = e;
                  end
               end
               checks++;
               if (bad) begin
                  errors++;
                  $display("FAIL R2 beat lane %0d (R1 lane order): actual %h expected %h", bl, ba, be);
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge wr_clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      int nfit;
      wr_rst_n = 1'b0; rd_rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0;
      repeat (5) @(negedge wr_clk);
      wr_rst_n = 1'b1; rd_rst_n = 1'b1;
      repeat (3) @(negedge wr_clk);
      check(wr_overflow == 1'b0, "R8", "overflow after reset", int'(wr_overflow), 0);
      check(rd_valid == 1'b0, "R8", "valid after reset", int'(rd_valid), 0);
      check(rd_underflow == 1'b0, "R8", "underflow after reset", int'(rd_underflow), 0);

      // Partial beat held, crossing delay, first beat.
      wr_blocks(1, 1'b1, 0);
      wait_rd(10);
      check(rd_valid == 1'b0, "R9", "7 samples must not form a beat", int'(rd_valid), 0);
      check(rd_underflow == 1'b0, "R6", "no read attempted yet", int'(rd_underflow), 0);
      wr_blocks(1, 1'b1, 0);
      check(rd_valid == 1'b0, "R7", "beat visible before two read edges", int'(rd_valid), 0);
      wait_rd(10);
      check(rd_valid == 1'b1, "R3", "valid with 14 samples", int'(rd_valid), 1);
      check(rd_data[W-1:0] == sval(0), "R1", "lane 0 holds oldest sample", int'(rd_data[W-1:0]), int'(sval(0)));
      check(rd_data[RL*W-1 -: W] == sval(7), "R1", "lane 7 holds 8th sample", int'(rd_data[RL*W-1 -: W]), int'(sval(7)));

      // Read one beat, then try again with only 6 samples left.
      rd_en = 1'b1;
      wait_rd(12);
      check(exp_q.size() == 6, "R2", "samples left after one beat", exp_q.size(), 6);
      check(rd_valid == 1'b0, "R9", "6 leftover samples held", int'(rd_valid), 0);
      check(rd_underflow == 1'b1, "R6", "underflow after empty read", int'(rd_underflow), 1);
      wr_blocks(1, 1'b1, 0);
      wait_rd(12);
      check(exp_q.size() == 5, "R6", "read position kept across underflow", exp_q.size(), 5);
      check(rd_underflow == 1'b1, "R6", "underflow sticky", int'(rd_underflow), 1);

      // Bursts of four blocks at full write rate.
      for (int r = 0; r < 25; r++) begin
         wr_blocks(4, 1'b1, 0);
         repeat (16) @(negedge wr_clk);
      end
      wait_rd(20);
      check(exp_q.size() < RL, "R2", "burst stream fully delivered", exp_q.size(), RL - 1);
      check(wr_overflow == 1'b0, "R4", "no overflow in burst stream", int'(wr_overflow), 0);

      // Gapped writes with read stalls.
      rd_gap = 1'b1;
      wr_blocks(60, 1'b1, 1);
      wait_rd(30);
      check(exp_q.size() < RL, "R2", "stalled stream fully delivered", exp_q.size(), RL - 1);
      rd_gap = 1'b0;

      // Fill to capacity, then overflow.
      rd_en = 1'b0;
      wait_rd(10);
      repeat (10) @(negedge wr_clk);
      nfit = (DEPTH - exp_q.size()) / WL;
      wr_blocks(nfit, 1'b1, 0);
      repeat (10) @(negedge wr_clk);
      check(wr_overflow == 1'b0, "R4", "blocks that fit are all accepted", int'(wr_overflow), 0);
      check(exp_q.size() <= DEPTH && exp_q.size() > DEPTH - WL, "R4", "buffered near capacity", exp_q.size(), DEPTH);
      wr_blocks(1, 1'b0, 0);
      repeat (3) @(negedge wr_clk);
      check(wr_overflow == 1'b1, "R5", "overflow on full write", int'(wr_overflow), 1);
      repeat (10) @(negedge wr_clk);
      check(wr_overflow == 1'b1, "R5", "overflow sticky", int'(wr_overflow), 1);
      rd_en = 1'b1;
      wait_rd(40);
      check(exp_q.size() < RL, "R5", "dropped block absent, rest delivered", exp_q.size(), RL - 1);

      // Reset both sides and restart.
      rd_en = 1'b0;
      wait_rd(5);
      wr_rst_n = 1'b0; rd_rst_n = 1'b0;
      repeat (3) @(negedge wr_clk);
      exp_q.delete();
      wr_rst_n = 1'b1; rd_rst_n = 1'b1;
      repeat (5) @(negedge wr_clk);
      check(wr_overflow == 1'b0, "R8", "overflow cleared by write reset", int'(wr_overflow), 0);
      check(rd_underflow == 1'b0, "R8", "underflow cleared by read reset", int'(rd_underflow), 0);
      check(rd_valid == 1'b0, "R8", "buffer empty after reset", int'(rd_valid), 0);
      wr_blocks(2, 1'b1, 0);
      rd_en = 1'b1;
      wait_rd(15);
      check(exp_q.size() == 6, "R8", "restart delivers from fresh positions", exp_q.size(), 6);
      check(rd_valid == 1'b0, "R9", "leftover after restart held", int'(rd_valid), 0);

      finish_sim();
   end
endmodule